// File: doc/BRIEF.md
# Single-Bit-Step Successive Approximation Controller

This controller drives the code of a converter's feedback DAC and refines it from the last conversion result rather than from mid-scale. Each comparison moves the code by exactly one bit. If the comparator reports that the input lies above the DAC level, the lowest cleared bit of the code is set. If it reports that the input lies below, the lowest set bit is cleared. Slowly moving inputs therefore settle in a few comparisons whenever the new value is reachable by short runs of such flips.

Two combinational finders isolate the lowest set bit. One works on the code and the other on its complement, and the comparator decision picks between the two candidate codes. A conversion ends when the comparator reports equality or when the comparison budget is spent. The final code is then latched as the result and seeds the next conversion.

Top module: `lsb_step_sar`

## Requirements
- R1: After reset, `result`, `dac_code`, `busy` and `done` are all zero.
- R2: A `start` seen while idle raises `busy` on the next cycle, and the first code presented on `dac_code` equals the current `result`.
- R3: While busy with `cmp_eq`=0 and `cmp_hi`=1, the next code is the present code with its least significant 0 bit set to 1.
- R4: While busy with `cmp_eq`=0 and `cmp_hi`=0, the next code is the present code with its least significant 1 bit cleared to 0.
- R5: An increase requested on an all-ones code, or a decrease requested on an all-zeros code, leaves the code unchanged.
- R6: `cmp_eq`=1 while busy ends the conversion. On the next cycle `busy` is 0, `result` equals the code that was compared, and `done` is high for exactly one cycle.
- R7: A conversion makes at most MAX_STEPS (default 10) comparisons. If none reports equality, `result` takes the code produced by the last step.
- R8: `start` is ignored while a conversion is running.
- R9: Starting from 1000001100 with the input at 1000011111, the codes 1000001101, 1000001111 and 1000011111 follow, so equality is reached on the fourth comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion (ignored while busy) |
| cmp_hi | input | 1 | Comparator: input above DAC level |
| cmp_eq | input | 1 | Comparator: input equals DAC level |
| dac_code | output | W | Code driving the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result updates |
| result | output | W | Last conversion result, seed of the next |

## Verification
Four properties are checked on every cycle: each step changes at most one bit, in the direction the comparator asks for; saturated codes hold; equality ends the run with a single `done` pulse; and no run exceeds the comparison budget. Only the bench scenarios can show that the result chain carries from one conversion to the next, that the comparison counts match for specific start and target pairs, and that a `start` arriving mid-run changes nothing.

// File: rtl/lsb_step_sar.sv
module lsb_step_sar #(
  parameter int W = 10,
  parameter int MAX_STEPS = W,
  localparam int CW = $clog2(MAX_STEPS + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         cmp_hi,
  input  logic         cmp_eq,
  output logic [W-1:0] dac_code,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  logic [W-1:0]  work;
  logic [CW-1:0] steps;

  wire [W-1:0] inv      = ~work;
  wire [W-1:0] low_zero = inv & (~inv + 1'b1);
  wire [W-1:0] low_one  = work & (~work + 1'b1);
  wire [W-1:0] up_code  = work | low_zero;
  wire [W-1:0] dn_code  = work & ~low_one;
  wire [W-1:0] nxt_code = cmp_hi ? up_code : dn_code;
  wire         last     = (steps == CW'(MAX_STEPS - 1));

  assign dac_code = work;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work   <= '0;
      steps  <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          work  <= result;
          steps <= '0;
        end
      end else if (cmp_eq) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= work;
      end else begin
        work  <= nxt_code;
        steps <= steps + 1'b1;
        if (last) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= nxt_code;
        end
      end
    end
  end
endmodule

// File: rtl/lsb_step_sar_chk.sv
module lsb_step_sar_chk #(
  parameter int W = 10,
  parameter int MAX_STEPS = W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         cmp_hi,
  input logic         cmp_eq,
  input logic [W-1:0] dac_code,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result
);
  int run_len;
  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= 0;
    else        run_len <= busy ? run_len + 1 : 0;
  end

  a_r2_seed_from_result: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && dac_code == $past(result)));

  a_r3_increase_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmp_eq && cmp_hi && !(&dac_code)) |=>
      (dac_code > $past(dac_code) && $countones(dac_code ^ $past(dac_code)) == 1));

  a_r4_decrease_clears_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmp_eq && !cmp_hi && dac_code != '0) |=>
      (dac_code < $past(dac_code) && $countones(dac_code ^ $past(dac_code)) == 1));

  a_r5_saturate_top: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmp_eq && cmp_hi && (&dac_code)) |=> $stable(dac_code));

  a_r5_saturate_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmp_eq && !cmp_hi && dac_code == '0) |=> $stable(dac_code));

  a_r6_equal_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmp_eq) |=> (!busy && done && result == $past(dac_code)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_budget: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < MAX_STEPS));
endmodule

bind lsb_step_sar lsb_step_sar_chk #(.W(W), .MAX_STEPS(MAX_STEPS)) chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cmp_hi(cmp_hi), .cmp_eq(cmp_eq),
  .dac_code(dac_code), .busy(busy), .done(done), .result(result)
);

// File: tb/lsb_step_sar_test.sv
module lsb_step_sar_test;
  localparam int W = 10;
  localparam int NV = 7;
  // target, expected result, expected comparisons; each run starts from the previous result
  localparam int VEC [NV][3] = '{
    '{0,   0,    1},
    '{524, 1023, 10},
    '{512, 512,  10},
    '{524, 524,  7},
    '{543, 543,  4},
    '{540, 540,  3},
    '{541, 541,  2}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic cmp_hi, cmp_eq;
  logic [W-1:0] dac_code, result;
  logic busy, done;
  int target = 0;
  logic force_on = 0, force_hi = 0;
  int errors = 0, checks = 0;
  int n_cmp;
  logic [W-1:0] first_code;
  logic hold_ok;

  always #2.5 clk = ~clk;

  always_comb begin
    cmp_eq = force_on ? 1'b0 : (int'(dac_code) == target);
    cmp_hi = force_on ? force_hi : (target > int'(dac_code));
  end

  lsb_step_sar #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_hi(cmp_hi), .cmp_eq(cmp_eq),
    .dac_code(dac_code), .busy(busy), .done(done), .result(result)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(input logic restart_mid, input int hold_val);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    first_code = dac_code;
    check("R2 busy after start", busy, 1);
    n_cmp = 0;
    hold_ok = 1;
    while (!done) begin
      if (busy) begin
        n_cmp++;
        if (hold_val >= 0 && n_cmp > 1 && int'(dac_code) != hold_val) hold_ok = 0;
      end
      if (restart_mid && n_cmp == 4) start = 1; else start = 0;
      @(negedge clk);
    end
    start = 0;
    check("R6 busy low with done", busy, 0);
    @(negedge clk);
    check("R6 done single pulse", done, 0);
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 result", result, 0);
    check("R1 dac_code", dac_code, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      int prev;
      prev = int'(result);
      target = VEC[i][0];
      convert(0, -1);
      check("R2 first code is previous result", first_code, prev);
      check(i == 4 ? "R9 example result" : "R6/R7 result", result, VEC[i][1]);
      check(i == 1 ? "R7 budget comparisons" : (i == 4 ? "R9 comparisons" : "R3/R4 comparisons"),
            n_cmp, VEC[i][2]);
    end

    // R3 forced increase from 541 reaches all ones, then R5 holds there
    force_on = 1; force_hi = 1;
    convert(0, -1);
    check("R3 forced increase result", result, 1023);
    check("R7 forced comparisons", n_cmp, 10);

    force_hi = 1;
    convert(0, 1023);
    check("R5 top hold result", result, 1023);
    check("R5 top code held", hold_ok, 1);

    // R4 forced decrease from all ones ends at zero after 10 steps
    force_hi = 0;
    convert(0, -1);
    check("R4 forced decrease result", result, 0);
    check("R4 comparisons", n_cmp, 10);

    // R5 bottom hold, with R8 start pulsed mid-run
    convert(1, 0);
    check("R5 bottom hold result", result, 0);
    check("R5 bottom code held", hold_ok, 1);
    check("R8 start ignored while busy", n_cmp, 10);
    repeat (2) @(negedge clk);
    check("R8 no restart after run", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule